// File: doc/BRIEF.md
# Shared-Bus SPI Slave with In-Frame Chip Address

This block is a slave on a serial peripheral bus that several identical devices share. It never starts a transfer. Every frame is eight bits long and is sent most significant bit first. The three bits that arrive first name the target device. Each device compares them with its own strap input while the frame is still arriving. Only the device that matches answers: it turns on its MISO driver and shifts out a five-bit status word that the surrounding logic supplies. While it does this, it keeps taking the rest of the MOSI bits.

When chip select goes back high after a complete, matching frame, the whole received byte is copied into the parallel write register and a one-cycle strobe marks the update. A frame that is addressed to another device, or that ends early, leaves the write register as it was.

The serial pins are oversampled by a local system clock. Chip select, the serial clock and MOSI each pass through a two-flop synchronizer. Every edge decision is made on the synchronized copies. Because of this, the clock's idle level does not matter, and the ports respond three system clocks after a pin changes.

Top module: `spi_addr_slave`

## Requirements
- R1: After reset, wr_word is 0, wr_stb is 0 and miso_oe is 0.
- R2: While cs_n is high, activity on sck and mosi changes neither wr_word nor wr_stb, and miso_oe stays 0.
- R3: A falling edge of cs_n clears the received bits and the bit count. Bits from an earlier aborted frame never appear in a later word.
- R4: A mosi bit is taken on each rising edge of sck while cs_n is low, most significant bit first. This works the same whether sck idles low or high.
- R5: Bits 7:5 of the frame (the first three received) form the chip address. On the third rising edge of sck it is compared with strap_addr, and on a match miso_oe goes to 1.
- R6: On a match, rd_word is captured at the third edge and sent MSB first. rd_word[4] is on miso_d after the third rising edge, and the next bit follows each later rising edge until rd_word[0] is presented after the seventh. miso_d stays steady between rising edges.
- R7: When cs_n rises after exactly eight or more bits of a matching frame, wr_word takes the first eight bits (first bit in bit 7) and wr_stb is 1 for one system clock.
- R8: If the address does not match, miso_oe stays 0 for the whole frame and the frame does not update wr_word or pulse wr_stb.
- R9: If cs_n rises before eight bits have been taken, wr_word and wr_stb are unchanged.
- R10: Rising edges of sck after the eighth bit are ignored; the bit count never exceeds eight.
- R11: miso_oe returns to 0 once cs_n is high.
- R12: A rising edge of sck that is synchronized in the same system clock as a cs_n edge (falling or rising) is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from the bus controller, active low |
| sck | input | 1 | Serial clock; may idle at either level |
| mosi | input | 1 | Serial data from the controller |
| strap_addr | input | ADDR_W | Chip address this device answers to |
| rd_word | input | FRAME_W-ADDR_W | Status word returned on MISO |
| miso_d | output | 1 | Serial data toward the controller |
| miso_oe | output | 1 | Drive enable for the external MISO buffer |
| wr_word | output | FRAME_W | Last committed write byte |
| wr_stb | output | 1 | One-cycle pulse on each committed write |

## Verification
The delicate case is a serial clock rising edge that arrives in the same system clock as a chip select edge. There are two ways this happens. The bench can raise cs_n together with the eighth sck rise, which must abort the commit. It can also lower cs_n together with an early sck rise, which must drop that bit so that the word is built from the next eight bits. Both are driven from one falling clock edge, so the synchronizers deliver the two edges in the same cycle. A behavioural reference built on queues predicts wr_word, wr_stb, miso_oe and miso_d on every clock, and direct checks confirm the committed byte.

// File: rtl/spi_addr_pkg.sv
package spi_addr_pkg;
  // indices into the synchronized control-pin history
  localparam int unsigned CTL_CS  = 0;
  localparam int unsigned CTL_SCK = 1;
  localparam int unsigned CTL_N   = 2;

  // one-bit edge helpers on a (current, previous) pair
  function automatic logic edge_up(input logic cur, input logic prv);
    return cur & ~prv;
  endfunction

  function automatic logic edge_dn(input logic cur, input logic prv);
    return ~cur & prv;
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter int unsigned TAPS    = 1,
  parameter logic [W-1:0] RST    = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [W-1:0]              pin,
  output logic [W-1:0][TAPS-1:0]    tap
);
  localparam int unsigned DEPTH = STAGES + TAPS - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [DEPTH-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {DEPTH{RST[b]}};
      else        pipe <= {pipe[DEPTH-2:0], pin[b]};
    end
    // tap[b][0] is the synchronized level, higher taps are older copies
    assign tap[b] = pipe[DEPTH-1 -: TAPS];
  end
endmodule

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl #(
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned ADDR_W  = 3,
  localparam int unsigned RD_W   = FRAME_W - ADDR_W,
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_lvl,
  input  logic               cs_fall,
  input  logic               cs_rise,
  input  logic               sck_rise,
  input  logic               mosi_lvl,
  input  logic [ADDR_W-1:0]  strap,
  input  logic [RD_W-1:0]    rd_word,
  output logic               bit_take,
  output logic               addr_chk,
  output logic               hit,
  output logic               frame_full,
  output logic [FRAME_W-1:0] frame_word,
  output logic [CNT_W-1:0]   bit_cnt,
  output logic               miso_d,
  output logic               miso_oe
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W - 1);

  logic [RD_W-1:0] rd_sh;
  logic            addr_ok;
  logic            shift_out;

  // address formed by the bits already held plus the one arriving now
  function automatic logic addr_match(input logic [FRAME_W-1:0] sh,
                                      input logic din,
                                      input logic [ADDR_W-1:0] want);
    return {sh[ADDR_W-2:0], din} == want;
  endfunction

  // rising edges after the address on which the next MISO bit is moved up
  function automatic logic in_shift_slot(input logic [CNT_W-1:0] c);
    return (c >= CNT_W'(ADDR_W)) && (c < CNT_W'(FRAME_W - 1));
  endfunction

  assign frame_full = (bit_cnt == CNT_FULL);
  assign bit_take   = ~cs_lvl & sck_rise & ~frame_full;
  assign addr_chk   = bit_take & (bit_cnt == CNT_ADDR);
  assign addr_ok    = addr_match(frame_word, mosi_lvl, strap);
  assign shift_out  = bit_take & hit & in_shift_slot(bit_cnt);
  assign miso_d     = rd_sh[RD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      frame_word <= '0;
      hit        <= 1'b0;
      miso_oe    <= 1'b0;
      rd_sh      <= '0;
    end else if (cs_fall) begin
      bit_cnt    <= '0;
      frame_word <= '0;
      hit        <= 1'b0;
      miso_oe    <= 1'b0;
    end else begin
      if (bit_take) begin
        frame_word <= {frame_word[FRAME_W-2:0], mosi_lvl};
        bit_cnt    <= bit_cnt + 1'b1;
      end
      if (addr_chk && addr_ok) begin
        hit     <= 1'b1;
        miso_oe <= 1'b1;
        rd_sh   <= rd_word;
      end else if (shift_out) begin
        rd_sh <= {rd_sh[RD_W-2:0], 1'b0};
      end
      if (cs_rise) begin
        hit     <= 1'b0;
        miso_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_wr_commit.sv
module spi_wr_commit #(
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [FRAME_W-1:0] frame_word,
  output logic [FRAME_W-1:0] wr_word,
  output logic               wr_stb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_word <= '0;
      wr_stb  <= 1'b0;
    end else begin
      wr_stb <= commit;
      if (commit) wr_word <= frame_word;
    end
  end
endmodule

// File: rtl/spi_addr_slave.sv
module spi_addr_slave #(
  parameter int unsigned FRAME_W     = 8,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned RD_W       = FRAME_W - ADDR_W,
  localparam int unsigned CNT_W      = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sck,
  input  logic               mosi,
  input  logic [ADDR_W-1:0]  strap_addr,
  input  logic [RD_W-1:0]    rd_word,
  output logic               miso_d,
  output logic               miso_oe,
  output logic [FRAME_W-1:0] wr_word,
  output logic               wr_stb
);
  import spi_addr_pkg::*;

  logic [CTL_N-1:0][1:0] ctl_tap;
  logic [0:0][0:0]       dat_tap;
  logic                  cs_lvl, cs_rise, cs_fall, sck_rise, mosi_lvl;
  logic                  bit_take, addr_chk, hit, frame_full, commit;
  logic [FRAME_W-1:0]    frame_word;
  logic [CNT_W-1:0]      bit_cnt;

  // chip select resets to idle-high, serial clock to low
  spi_in_sync #(.W(CTL_N), .STAGES(SYNC_STAGES), .TAPS(2),
                .RST(CTL_N'(1) << CTL_CS)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .pin({sck, cs_n}), .tap(ctl_tap)
  );

  spi_in_sync #(.W(1), .STAGES(SYNC_STAGES), .TAPS(1), .RST(1'b0)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .pin(mosi), .tap(dat_tap)
  );

  assign cs_lvl   = ctl_tap[CTL_CS][0];
  assign cs_rise  = edge_up(ctl_tap[CTL_CS][0],  ctl_tap[CTL_CS][1]);
  assign cs_fall  = edge_dn(ctl_tap[CTL_CS][0],  ctl_tap[CTL_CS][1]);
  assign sck_rise = edge_up(ctl_tap[CTL_SCK][0], ctl_tap[CTL_SCK][1]);
  assign mosi_lvl = dat_tap[0][0];

  spi_shift_ctrl #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sck_rise(sck_rise), .mosi_lvl(mosi_lvl),
    .strap(strap_addr), .rd_word(rd_word), .bit_take(bit_take),
    .addr_chk(addr_chk), .hit(hit), .frame_full(frame_full),
    .frame_word(frame_word), .bit_cnt(bit_cnt), .miso_d(miso_d),
    .miso_oe(miso_oe)
  );

  assign commit = cs_rise & frame_full & hit;

  spi_wr_commit #(.FRAME_W(FRAME_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .commit(commit), .frame_word(frame_word),
    .wr_word(wr_word), .wr_stb(wr_stb)
  );
endmodule

// File: rtl/spi_addr_slave_chk.sv
module spi_addr_slave_chk #(
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_lvl,
  input logic               cs_rise,
  input logic               bit_take,
  input logic               addr_chk,
  input logic [CNT_W-1:0]   bit_cnt,
  input logic               miso_oe,
  input logic               miso_d,
  input logic               wr_stb,
  input logic [FRAME_W-1:0] wr_word
);
  // R11
  oe_off_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl && $past(cs_lvl) |-> !miso_oe);

  // R5
  oe_on_at_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> $past(addr_chk));

  // R7
  stb_after_full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(cs_rise) && ($past(bit_cnt) == CNT_W'(FRAME_W)));

  // R7
  stb_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R9
  word_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable(wr_word));

  // R6
  miso_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe && $past(miso_oe) && !$past(bit_take) |-> $stable(miso_d));

  // R10
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W));
endmodule

bind spi_addr_slave spi_addr_slave_chk #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .cs_rise(cs_rise),
  .bit_take(bit_take), .addr_chk(addr_chk), .bit_cnt(bit_cnt),
  .miso_oe(miso_oe), .miso_d(miso_d), .wr_stb(wr_stb), .wr_word(wr_word)
);

// File: tb/spi_addr_slave_bench.sv
module spi_addr_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, sck, mosi;
  logic [2:0] strap_addr;
  logic [4:0] rd_word;
  logic       miso_d, miso_oe, wr_stb;
  logic [7:0] wr_word;

  int vectors = 0, miscompares = 0, stb_seen = 0, oe_cnt = 0;
  bit ready = 0;

  spi_addr_slave u_spi_addr_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .strap_addr(strap_addr), .rd_word(rd_word), .miso_d(miso_d),
    .miso_oe(miso_oe), .wr_word(wr_word), .wr_stb(wr_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  bit         q_cs[$], q_sck[$], q_mosi[$];
  bit         m_frame[$], m_rd[$];
  int         m_n;
  bit         m_hit, m_oe, m_stb;
  logic [7:0] m_wr;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_cs = '{1, 1, 1}; q_sck = '{0, 0, 0}; q_mosi = '{0, 0, 0};
      m_frame.delete(); m_rd.delete();
      m_n = 0; m_hit = 0; m_oe = 0; m_stb = 0; m_wr = 8'h00; ready = 1;
    end else begin
      bit cs_now, cs_old, clk_up, din;
      cs_now = q_cs[1]; cs_old = q_cs[0];
      clk_up = q_sck[1] && !q_sck[0];
      din    = q_mosi[1];
      m_stb  = 0;
      if (!cs_now && cs_old) begin
        m_n = 0; m_frame.delete(); m_hit = 0; m_oe = 0;
      end else begin
        if (!cs_now && clk_up && m_n < 8) begin
          m_frame.push_back(din);
          m_n++;
          if (m_n == 3) begin
            if ({m_frame[0], m_frame[1], m_frame[2]} == strap_addr) begin
              m_hit = 1; m_oe = 1; m_rd.delete();
              for (int i = 4; i >= 0; i--) m_rd.push_back(rd_word[i]);
            end
          end else if (m_hit && m_n >= 4 && m_n <= 7) begin
            void'(m_rd.pop_front());
          end
        end
        if (cs_now && !cs_old) begin
          if (m_n == 8 && m_hit) begin
            for (int i = 0; i < 8; i++) m_wr[7-i] = m_frame[i];
            m_stb = 1;
          end
          m_oe = 0; m_hit = 0;
        end
      end
      q_cs.push_back(cs_n);     void'(q_cs.pop_front());
      q_sck.push_back(sck);     void'(q_sck.pop_front());
      q_mosi.push_back(mosi);   void'(q_mosi.pop_front());
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && ready) begin
      vectors += 3;
      if (wr_word !== m_wr) begin
        miscompares++; $display("FAIL R7 wr_word act %h exp %h", wr_word, m_wr);
      end
      if (wr_stb !== m_stb) begin
        miscompares++; $display("FAIL R7 wr_stb act %0b exp %0b", wr_stb, m_stb);
      end
      if (miso_oe !== m_oe) begin
        miscompares++; $display("FAIL R5 miso_oe act %0b exp %0b", miso_oe, m_oe);
      end
      if (m_oe) begin
        vectors++;
        if (miso_d !== m_rd[0]) begin
          miscompares++; $display("FAIL R6 miso_d act %0b exp %0b", miso_d, m_rd[0]);
        end
      end
      if (wr_stb) stb_seen++;
      if (miso_oe) oe_cnt++;
    end
  end

  // ---------------- helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [7:0] b, input int nbits, input bit idle_hi,
                           output logic [4:0] got);
    got = '0;
    sck = idle_hi; tick(2);
    cs_n = 0; tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      sck = 0; mosi = (i < 8) ? b[7-i] : 1'b1; tick(HALF);
      if (i >= 3 && i < 8) got[7-i] = miso_d;
      sck = 1; tick(HALF);
    end
    if (!idle_hi) sck = 0;
    tick(HALF); cs_n = 1; tick(8);
  endtask

  // eighth rising edge of sck lands together with cs_n rising
  task automatic frame_late_cs(input logic [7:0] b);
    sck = 0; tick(2); cs_n = 0; tick(HALF);
    for (int i = 0; i < 8; i++) begin
      sck = 0; mosi = b[7-i]; tick(HALF);
      sck = 1;
      if (i == 7) cs_n = 1;
      tick(HALF);
    end
    sck = 0; tick(8);
  endtask

  // an sck rise arrives together with cs_n falling, then eight clean bits
  task automatic frame_early_sck(input logic [7:0] b);
    sck = 0; tick(2);
    cs_n = 0; sck = 1; mosi = 1; tick(HALF);
    for (int i = 0; i < 8; i++) begin
      sck = 0; mosi = b[7-i]; tick(HALF);
      sck = 1; tick(HALF);
    end
    sck = 0; tick(HALF); cs_n = 1; tick(8);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [4:0] got;
    int         s0, o0;
    rst_n = 0; cs_n = 1; sck = 0; mosi = 0;
    strap_addr = 3'b101; rd_word = 5'b10110;
    tick(5); rst_n = 1; tick(2);

    // R1 reset state
    chk(wr_word == 8'h00, "R1 wr_word", wr_word, 0);
    chk(wr_stb == 1'b0,   "R1 wr_stb", wr_stb, 0);
    chk(miso_oe == 1'b0,  "R1 miso_oe", miso_oe, 0);

    // R2 bus activity while deselected
    o0 = oe_cnt;
    for (int i = 0; i < 12; i++) begin
      sck = ~sck; mosi = i[0]; tick(3);
    end
    sck = 0; tick(6);
    chk(stb_seen == 0, "R2 strobes", stb_seen, 0);
    chk(wr_word == 8'h00, "R2 wr_word", wr_word, 0);
    chk(oe_cnt == o0, "R2 oe cycles", oe_cnt - o0, 0);

    // R4 R5 R6 R7 matching frame, sck idle low
    run_frame(8'b101_01101, 8, 0, got);
    chk(wr_word == 8'hAD, "R7 word idle-low", wr_word, 8'hAD);
    chk(stb_seen == 1, "R7 strobe count", stb_seen, 1);
    chk(got == 5'b10110, "R6 miso bits", got, 5'b10110);
    chk(miso_oe == 1'b0, "R11 oe after cs high", miso_oe, 0);

    // R4 same with sck idle high and a new status word
    rd_word = 5'b01001;
    run_frame(8'b101_10010, 8, 1, got);
    chk(wr_word == 8'hB2, "R4 word idle-high", wr_word, 8'hB2);
    chk(got == 5'b01001, "R6 miso bits idle-high", got, 5'b01001);

    // R8 address mismatch
    s0 = stb_seen; o0 = oe_cnt;
    run_frame(8'b011_11111, 8, 0, got);
    chk(stb_seen == s0, "R8 no strobe", stb_seen - s0, 0);
    chk(wr_word == 8'hB2, "R8 word kept", wr_word, 8'hB2);
    chk(oe_cnt == o0, "R8 oe never on", oe_cnt - o0, 0);

    // R9 short frame, address matches
    s0 = stb_seen;
    run_frame(8'b101_00000, 5, 0, got);
    chk(stb_seen == s0, "R9 no strobe", stb_seen - s0, 0);
    chk(wr_word == 8'hB2, "R9 word kept", wr_word, 8'hB2);

    // R3 aborted frame followed by a clean one
    run_frame(8'b111_11111, 6, 0, got);
    run_frame(8'b101_00001, 8, 1, got);
    chk(wr_word == 8'hA1, "R3 fresh word", wr_word, 8'hA1);

    // R10 extra clocks past the eighth bit
    run_frame(8'b101_11000, 11, 0, got);
    chk(wr_word == 8'hB8, "R10 first eight bits", wr_word, 8'hB8);

    // R5 a different strap value
    strap_addr = 3'b010; rd_word = 5'b11100;
    run_frame(8'b010_00110, 8, 0, got);
    chk(wr_word == 8'h46, "R5 other strap", wr_word, 8'h46);
    chk(got == 5'b11100, "R5 miso under other strap", got, 5'b11100);

    // R12 eighth sck rise coincides with cs_n rising: aborted
    s0 = stb_seen;
    frame_late_cs(8'b010_10101);
    chk(stb_seen == s0, "R12 late cs no strobe", stb_seen - s0, 0);
    chk(wr_word == 8'h46, "R12 late cs word kept", wr_word, 8'h46);

    // R12 sck rise coincides with cs_n falling: that bit dropped
    frame_early_sck(8'b010_01011);
    chk(wr_word == 8'h4B, "R12 early sck dropped", wr_word, 8'h4B);

    tick(10);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog act %0d exp below %0d cycles", WATCHDOG, WATCHDOG);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule